// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block sits between a CPU core and an external asynchronous SRAM-style memory. The core raises a request carrying an address, write data, a direction flag and a wait count. The block then runs a single external transfer. It presents the address, drives chip select, write strobe, output enable and the data bus, and returns a one-clock done pulse when the transfer is over. For reads, the captured word is returned with that pulse.

Every transfer has the same fixed phases: select, strobe, an optional stretch of wait clocks, a final strobe clock and a release clock. The wait count is set per request. This lets the core clock run faster than the memory's access time: each extra wait clock extends the strobe by one period. The read enable is shaped from two flops. One is clocked on the rising edge and one on the falling edge, so the enable opens half a clock after the strobe phase begins, which gives the address time to settle.

Top module: `memcyc_ctrl`

## Requirements
- R1: After reset, `idle_o` is 1, `ack_o` is 0, `rdata_o` is 0, `mem_dq_oe_o` is 0, and `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are all 1.
- R2: A request is taken only on a rising edge where `idle_o` is 1 and `req_i` is 1. While a transfer runs, `req_i` has no effect, and `req_i` held high during a transfer starts the next transfer on the first idle clock.
- R3: With wait count N sampled from `wait_cfg_i` at acceptance, a transfer takes exactly 4+N clocks from its first non-idle clock through its release clock. `ack_o` is 1 only in the release clock and `idle_o` is 0 throughout the transfer.
- R4: `mem_ce_n_o` is 0 from the first clock of the transfer through the final strobe clock and is 1 in the release clock.
- R5: For a write (`req_we_i`=1), `mem_we_n_o` is 0 from the strobe clock through the final strobe clock and is 1 in the select and release clocks. `mem_dq_oe_o` is 1 and `mem_dout_o` carries the accepted write data for every clock of the transfer. For a read, `mem_we_n_o` stays 1 and `mem_dq_oe_o` stays 0.
- R6: For a read, `mem_oe_n_o` is the OR of a rising-edge strobe (low from the strobe clock through the final strobe clock) and a copy of that strobe taken on the falling edge. OE# therefore falls half a clock into the strobe clock and rises at the start of the release clock. It is never 0 during a write.
- R7: `mem_addr_o` carries the accepted address for every clock of the transfer and does not change within it.
- R8: Read data is sampled from `mem_din_i` on the rising edge that ends the final strobe clock. It appears on `rdata_o` from the release clock onward and holds until the next read completes. Writes leave it unchanged.
- R9: Changes on `wait_cfg_i`, `req_addr_i`, `req_wdata_i` and `req_we_i` after acceptance do not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge for the sequencer, falling edge for the OE# shaping flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, sampled only when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Transfer address |
| req_wdata_i | input | DATA_W | Write data |
| wait_cfg_i | input | WAIT_W | Number of extra wait clocks |
| idle_o | output | 1 | Sequencer idle, a request can be taken |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Last read word |
| mem_addr_o | output | ADDR_W | External address |
| mem_dout_o | output | DATA_W | External write data |
| mem_din_i | input | DATA_W | External read data |
| mem_dq_oe_o | output | 1 | Drive enable for the external data bus |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |

## Verification
A request driven before edge k is taken at edge k. Select, address and data-bus drive are due one clock later, write strobe and the rising-edge read strobe two clocks later, and OE# half a clock after that. Read data and the done pulse are due 4+N edges after acceptance. The bench samples the pin strobes 1 ns after each rising edge, and samples OE# a second time 1 ns after the falling edge, so both halves of its shaping are checked. The bench memory returns a valid word only after OE# has been low for N+2 such falling-edge samples. A capture taken one clock early therefore returns a poison word.

// File: rtl/memcyc_pkg.sv
`timescale 1ns/1ps
package memcyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_WAIT    = 3'd3,
    PH_LAST    = 3'd4,
    PH_RELEASE = 3'd5
  } phase_t;

  // chip select is held across setup and all strobe phases
  function automatic logic ph_selected(phase_t p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_WAIT) || (p == PH_LAST);
  endfunction

  // read or write strobe is active in these phases
  function automatic logic ph_strobing(phase_t p);
    return (p == PH_STROBE) || (p == PH_WAIT) || (p == PH_LAST);
  endfunction

  // clocks spent in non-idle phases for a given wait count
  function automatic int unsigned cycle_clocks(int unsigned waits);
    return waits + 4;
  endfunction

endpackage

// File: rtl/memcyc_seq.sv
`timescale 1ns/1ps
module memcyc_seq
  import memcyc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WAIT_W-1:0] wait_i,
  output phase_t            phase_q,
  output phase_t            phase_d,
  output logic              accept_o,
  output logic              capture_o,
  output logic              finish_o
);

  logic [WAIT_W-1:0] cnt_q;
  logic              cnt_zero;
  logic              cnt_one;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == WAIT_W'(1));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (req_i) phase_d = PH_SETUP;
      PH_SETUP:   phase_d = PH_STROBE;
      PH_STROBE:  phase_d = cnt_zero ? PH_LAST : PH_WAIT;
      PH_WAIT:    phase_d = cnt_one ? PH_LAST : PH_WAIT;
      PH_LAST:    phase_d = PH_RELEASE;
      PH_RELEASE: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_SETUP) begin
        cnt_q <= wait_i;
      end else if (phase_q == PH_WAIT) begin
        cnt_q <= cnt_q - WAIT_W'(1);
      end
    end
  end

  assign accept_o  = (phase_q == PH_IDLE) && req_i;
  assign capture_o = (phase_q == PH_LAST);
  assign finish_o  = (phase_q == PH_RELEASE);

endmodule

// File: rtl/memcyc_hold.sv
`timescale 1ns/1ps
module memcyc_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [WAIT_W-1:0] wait_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wait_q  <= '0;
    end else if (accept_i) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wait_q  <= wait_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_i && !we_q) begin
      rdata_q <= din_i;
    end
  end

endmodule

// File: rtl/memcyc_pins.sv
`timescale 1ns/1ps
module memcyc_pins
  import memcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_q,
  input  phase_t phase_d,
  input  logic   we_q,
  output logic   ce_n_o,
  output logic   we_n_o,
  output logic   oe_n_o,
  output logic   dq_oe_o,
  output logic   rd_rise_n_o,
  output logic   rd_fall_n_o
);

  // rising-edge strobes, loaded from the next phase so pins are flop outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_o      <= 1'b1;
      we_n_o      <= 1'b1;
      rd_rise_n_o <= 1'b1;
    end else begin
      ce_n_o      <= !ph_selected(phase_d);
      we_n_o      <= !(ph_strobing(phase_d) && we_q);
      rd_rise_n_o <= !(ph_strobing(phase_d) && !we_q);
    end
  end

  // falling-edge copy delays the opening of OE# by half a clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_fall_n_o <= 1'b1;
    end else begin
      rd_fall_n_o <= rd_rise_n_o;
    end
  end

  // active-low AND of the two strobes
  assign oe_n_o  = rd_rise_n_o | rd_fall_n_o;
  assign dq_oe_o = we_q && (phase_q != PH_IDLE);

endmodule

// File: rtl/memcyc_ctrl.sv
`timescale 1ns/1ps
module memcyc_ctrl
  import memcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic              mem_dq_oe_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o
);

  phase_t            phase_q;
  phase_t            phase_d;
  logic              accept;
  logic              capture;
  logic              finish;
  logic              we_q;
  logic [WAIT_W-1:0] wait_q;
  logic              rd_rise_n;
  logic              rd_fall_n;

  memcyc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wait_i    (wait_q),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .accept_o  (accept),
    .capture_o (capture),
    .finish_o  (finish)
  );

  memcyc_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .capture_i (capture),
    .we_i      (req_we_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .wait_i    (wait_cfg_i),
    .din_i     (mem_din_i),
    .we_q      (we_q),
    .addr_q    (mem_addr_o),
    .wdata_q   (mem_dout_o),
    .wait_q    (wait_q),
    .rdata_q   (rdata_o)
  );

  memcyc_pins u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_q     (phase_q),
    .phase_d     (phase_d),
    .we_q        (we_q),
    .ce_n_o      (mem_ce_n_o),
    .we_n_o      (mem_we_n_o),
    .oe_n_o      (mem_oe_n_o),
    .dq_oe_o     (mem_dq_oe_o),
    .rd_rise_n_o (rd_rise_n),
    .rd_fall_n_o (rd_fall_n)
  );

  assign idle_o = (phase_q == PH_IDLE);
  assign ack_o  = finish;

endmodule

// File: rtl/memcyc_chk.sv
`timescale 1ns/1ps
module memcyc_chk
  import memcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input phase_t            phase,
  input logic              accept,
  input logic              idle_o,
  input logic              ack_o,
  input logic [WAIT_W-1:0] wait_q,
  input logic              rise_n,
  input logic              fall_n,
  input logic              mem_ce_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] rdata_o
);

  localparam int LW = WAIT_W + 3;

  logic [LW-1:0] len_q;
  logic [LW-1:0] len_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                len_q <= '0;
    else if (accept)           len_q <= '0;
    else if (phase != PH_IDLE) len_q <= len_q + LW'(1);
  end

  assign len_exp = LW'(cycle_clocks(int'(wait_q)) - 1);

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> idle_o); // R2

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (len_q == len_exp)); // R3

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R3

  AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o || !rise_n) |-> !mem_ce_n_o); // R4

  AST_WE_OFF_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> mem_we_n_o); // R5

  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> mem_we_n_o); // R6

  AST_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> (!rise_n && !fall_n)); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_SETUP) |-> $stable(mem_addr_o)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RELEASE) |-> $stable(rdata_o)); // R8

endmodule

bind memcyc_ctrl memcyc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase_q),
  .accept     (accept),
  .idle_o     (idle_o),
  .ack_o      (ack_o),
  .wait_q     (wait_q),
  .rise_n     (rd_rise_n),
  .fall_n     (rd_fall_n),
  .mem_ce_n_o (mem_ce_n_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_addr_o (mem_addr_o),
  .rdata_o    (rdata_o)
);

// File: tb/test_memcyc_ctrl.sv
`timescale 1ns/1ps
module test_memcyc_ctrl;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WW-1:0] wait_cfg = '0;
  logic          idle, ack, dq_oe, ce_n, oe_n, we_n;
  logic [DW-1:0] rdata, dout, din;
  logic [AW-1:0] maddr;

  int total = 0;
  int bad = 0;

  // slow bench memory: valid only after OE# has been low long enough
  logic [DW-1:0] mem [16];
  int lowcnt = 0;
  int thr = 2;
  assign din = (!oe_n && lowcnt >= thr) ? mem[maddr[3:0]] : 32'hBAD0_BAD0;

  always #2 clk = ~clk;

  memcyc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) i_memcyc_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .wait_cfg_i(wait_cfg),
    .idle_o(idle), .ack_o(ack), .rdata_o(rdata), .mem_addr_o(maddr),
    .mem_dout_o(dout), .mem_din_i(din), .mem_dq_oe_o(dq_oe),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n)
  );

  // reference model state
  bit            m_busy = 0;
  int            m_pos = 0;
  int            m_n = 0;
  bit            m_we = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW-1:0] m_rdata = '0;
  bit            m_rd_now = 0;
  bit            m_rd_prev = 0;
  int            acks = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (m_busy && !m_we && m_pos == m_n + 2) m_rdata = mem[m_addr[3:0]];
    if (!m_busy) begin
      if (req) begin
        m_busy = 1; m_pos = 0; m_n = int'(wait_cfg);
        m_we = req_we; m_addr = req_addr; m_wdata = req_wdata;
      end
    end else if (m_pos == m_n + 3) begin
      m_busy = 0;
    end else begin
      m_pos++;
    end
    m_rd_prev = m_rd_now;
    m_rd_now  = m_busy && !m_we && m_pos >= 1 && m_pos <= m_n + 2;
  endtask

  task automatic tick();
    bit strobe;
    @(posedge clk);
    model_edge();
    #1;
    strobe = m_busy && m_pos >= 1 && m_pos <= m_n + 2;
    chk("R2 idle", {31'd0, idle}, {31'd0, !m_busy});
    chk("R3 ack", {31'd0, ack}, {31'd0, m_busy && m_pos == m_n + 3});
    chk("R4 ce_n", {31'd0, ce_n}, {31'd0, !(m_busy && m_pos <= m_n + 2)});
    chk("R5 we_n", {31'd0, we_n}, {31'd0, !(strobe && m_we)});
    chk("R5 dq_oe", {31'd0, dq_oe}, {31'd0, m_busy && m_we});
    chk("R6 oe_n first half", {31'd0, oe_n}, {31'd0, !(m_rd_now && m_rd_prev)});
    chk("R8 rdata", rdata, m_rdata);
    if (m_busy) begin
      chk("R7 addr", {16'd0, maddr}, {16'd0, m_addr});
      if (m_we) chk("R5 dout", dout, m_wdata);
    end
    if (ack) acks++;
    #2;
    chk("R6 oe_n second half", {31'd0, oe_n}, {31'd0, !m_rd_now});
    if (!oe_n) lowcnt++; else lowcnt = 0;
  endtask

  // drive one request, optionally disturb inputs mid-transfer, run to idle
  task automatic issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d, int w, bit disturb);
    req = 1; req_we = we; req_addr = a; req_wdata = d; wait_cfg = WW'(w);
    thr = w + 2;
    tick();
    req = 0;
    if (disturb) begin
      wait_cfg = WW'(w + 5); req_addr = ~a; req_wdata = ~d; req_we = !we; // R9
    end
    while (m_busy) tick();
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0102_0304);
    #3;
    // R1 reset state
    chk("R1 idle", {31'd0, idle}, 32'd1);
    chk("R1 ack", {31'd0, ack}, 32'd0);
    chk("R1 ce_n", {31'd0, ce_n}, 32'd1);
    chk("R1 oe_n", {31'd0, oe_n}, 32'd1);
    chk("R1 we_n", {31'd0, we_n}, 32'd1);
    chk("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst_n = 1;
    tick(); tick();
    issue(1, 16'h0003, 32'h1234_5678, 0, 0);   // R3 minimum write
    issue(0, 16'h0005, '0, 0, 0);              // R3 R8 minimum read
    issue(0, 16'h000A, '0, 3, 0);              // R3 stretched read
    issue(1, 16'h0101, 32'hCAFE_F00D, 2, 0);   // R5 stretched write, R8 rdata kept
    issue(0, 16'h000C, '0, 7, 1);              // R9 inputs disturbed mid-transfer
    issue(1, 16'h0F02, 32'h0BAD_CAFE, 1, 1);   // R9 on a write
    // R2 request held high: back-to-back transfers
    req = 1; req_we = 1; req_addr = 16'h0044; req_wdata = 32'h5555_AAAA; wait_cfg = 4'd1;
    for (int k = 0; k < 14; k++) tick();
    req = 0;
    while (m_busy) tick();
    a0 = acks;
    chk("R2 ack count", a0, 9);
    for (int k = 0; k < 4; k++) tick();
    issue(0, 16'h000F, '0, 15, 0);             // R3 longest wait
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule